// File: doc/BRIEF.md
# Shared-Pin Test Access Port Controller

This block holds the sixteen-state boundary-scan state machine. The machine advances on every rising edge of the test clock, and the test-mode-select input sets the path it takes. The block also decides who owns the pins that the test port shares with the rest of the chip. Static configuration inputs choose between two modes. In the first mode the pins belong to test logic at all times. In the second mode, the data-in, clock and data-out pins serve user logic while the controller rests in its reset state. They pass to test logic once the controller leaves that state.

A second static option makes the test-reset pin an asynchronous reset for the controller. Without that option the pin is ordinary user I/O, and its output enable comes from user logic. The block decodes the state into capture, shift, update and idle strobes for the scan chains. It also drives the output enable of the data-out pin and gives pull-up enable flags for the select and data-in pins. Scan cells, instruction decoding and pad circuits sit outside this block.

Top module: `shared_tap_ctrl`

## Requirements
- R1: While `porN` is low, and after it rises until the first rising `tck`, `tapState` is 4'hF (Test-Logic-Reset). The encoding is F reset, C run-idle, 7 select-DR, 6 capture-DR, 2 shift-DR, 1 exit1-DR, 3 pause-DR, 0 exit2-DR, 5 update-DR, 4 select-IR, E capture-IR, A shift-IR, 9 exit1-IR, B pause-IR, 8 exit2-IR, D update-IR.
- R2: On each rising `tck`, `tapState` moves to the next state that the standard 1149.1 transition graph gives for the sampled `tms`.
- R3: Five consecutive rising `tck` edges with `tms` high leave `tapState` at F, whatever the starting state. Four such edges from shift-IR do not reach F.
- R4: With `dedicatedMode` low, `pinSel[2:0]` (bit0 data-in, bit1 clock, bit2 data-out; 1 = test, 0 = user) is 3'b000 while `tapState` is F and 3'b111 in every other state. The switch happens on the rising edge that samples `tms` low in state F.
- R5: With `dedicatedMode` high, `pinSel` is all ones in every state, including bit3 (the test-reset pin).
- R6: With `trstResetEn` high, `trstPin` low forces `tapState` to F without waiting for a clock edge. It holds it there through clock edges with `tms` low.
- R7: With `trstResetEn` low and `dedicatedMode` low, `trstPin` has no effect on `tapState`, `pinSel[3]` is 0, and `trstPadOe` follows `userTrstOe`. When the test-reset pin is owned by test logic, `trstPadOe` is 0.
- R8: `pullupEn` (bit0 select pin, bit1 data-in pin) is 2'b11 in dedicated mode and 2'b00 in flexible mode.
- R9: `runIdle`, `captureDr`, `shiftDr`, `updateDr`, `captureIr`, `shiftIr` and `updateIr` are each high exactly while `tapState` holds the matching state. At most one of them is high at a time.
- R10: `tdoOe` is high only in shift-DR or shift-IR, and only while `pinSel[2]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, rising edge advances the controller |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select |
| trstPin | input | 1 | Test-reset pin level, active low when enabled |
| dedicatedMode | input | 1 | Static: 1 pins always test, 0 flexible sharing (default) |
| trstResetEn | input | 1 | Static: 1 test-reset pin acts as controller reset |
| userTrstOe | input | 1 | User logic output enable for the test-reset pin |
| tapState | output | 4 | Current controller state code |
| pinSel | output | 4 | Ownership per pin: data-in, clock, data-out, test-reset |
| tdoOe | output | 1 | Output enable for the data-out pad |
| trstPadOe | output | 1 | Output enable for the test-reset pad |
| pullupEn | output | 2 | Pull-up enables: select pin, data-in pin |
| runIdle | output | 1 | Controller is in run-idle |
| captureDr | output | 1 | Data register capture strobe |
| shiftDr | output | 1 | Data register shift strobe |
| updateDr | output | 1 | Data register update strobe |
| captureIr | output | 1 | Instruction register capture strobe |
| shiftIr | output | 1 | Instruction register shift strobe |
| updateIr | output | 1 | Instruction register update strobe |

## Verification
A wrong state register shows on `tapState` within one `tck` edge of the wrong transition. In flexible mode the damage spreads further: the pin ownership flips at the wrong moment, so user I/O is lost or kept one edge too long, and `tdoOe` may fire outside a shift. A miscounted exit path shows up only when the five-edge return to reset fails, so every pass through the state graph ends with that check. The asynchronous test reset is sampled between clock edges to show it does not wait for `tck`.

// File: rtl/tapPkg.sv
package tapPkg;

  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    stExit2Dr   = 4'h0,
    stExit1Dr   = 4'h1,
    stShiftDr   = 4'h2,
    stPauseDr   = 4'h3,
    stSelIr     = 4'h4,
    stUpdDr     = 4'h5,
    stCapDr     = 4'h6,
    stSelDr     = 4'h7,
    stExit2Ir   = 4'h8,
    stExit1Ir   = 4'h9,
    stShiftIr   = 4'hA,
    stPauseIr   = 4'hB,
    stRunIdle   = 4'hC,
    stUpdIr     = 4'hD,
    stCapIr     = 4'hE,
    stLogicRst  = 4'hF
  } tapState_e;

  // strobes decoded from the state for the scan chains
  typedef struct packed {
    logic idle;
    logic capDr;
    logic shDr;
    logic updDr;
    logic capIr;
    logic shIr;
    logic updIr;
  } scanStrobe_t;

  // what the control hands the pin datapath
  typedef struct packed {
    logic inReset;
    logic shiftAny;
  } ownCtl_t;

endpackage

// File: rtl/tapFsm.sv
module tapFsm
  import tapPkg::*;
(
  input  logic               tck,
  input  logic               rstN,
  input  logic               tms,
  output logic [STATE_W-1:0] stateOut,
  output scanStrobe_t        strobes,
  output ownCtl_t            ownCtl
);

  tapState_e stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      stLogicRst: stateNext = tms ? stLogicRst : stRunIdle;
      stRunIdle:  stateNext = tms ? stSelDr    : stRunIdle;
      stSelDr:    stateNext = tms ? stSelIr    : stCapDr;
      stCapDr:    stateNext = tms ? stExit1Dr  : stShiftDr;
      stShiftDr:  stateNext = tms ? stExit1Dr  : stShiftDr;
      stExit1Dr:  stateNext = tms ? stUpdDr    : stPauseDr;
      stPauseDr:  stateNext = tms ? stExit2Dr  : stPauseDr;
      stExit2Dr:  stateNext = tms ? stUpdDr    : stShiftDr;
      stUpdDr:    stateNext = tms ? stSelDr    : stRunIdle;
      stSelIr:    stateNext = tms ? stLogicRst : stCapIr;
      stCapIr:    stateNext = tms ? stExit1Ir  : stShiftIr;
      stShiftIr:  stateNext = tms ? stExit1Ir  : stShiftIr;
      stExit1Ir:  stateNext = tms ? stUpdIr    : stPauseIr;
      stPauseIr:  stateNext = tms ? stExit2Ir  : stPauseIr;
      stExit2Ir:  stateNext = tms ? stUpdIr    : stShiftIr;
      stUpdIr:    stateNext = tms ? stSelDr    : stRunIdle;
      default:    stateNext = stLogicRst;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) stateQ <= stLogicRst;
    else       stateQ <= stateNext;
  end

  always_comb begin
    strobes.idle  = (stateQ == stRunIdle);
    strobes.capDr = (stateQ == stCapDr);
    strobes.shDr  = (stateQ == stShiftDr);
    strobes.updDr = (stateQ == stUpdDr);
    strobes.capIr = (stateQ == stCapIr);
    strobes.shIr  = (stateQ == stShiftIr);
    strobes.updIr = (stateQ == stUpdIr);
    ownCtl.inReset  = (stateQ == stLogicRst);
    ownCtl.shiftAny = strobes.shDr | strobes.shIr;
  end

  assign stateOut = stateQ;

endmodule

// File: rtl/pinOwner.sv
module pinOwner
  import tapPkg::*;
#(
  parameter int SHARED_PINS = 3
) (
  input  ownCtl_t              ownCtl,
  input  logic                 dedicatedMode,
  input  logic                 trstResetEn,
  input  logic                 userTrstOe,
  output logic [SHARED_PINS:0] pinSel,
  output logic                 tdoOe,
  output logic                 trstPadOe,
  output logic [1:0]           pullupEn
);

  localparam int TDO_IDX  = SHARED_PINS - 1;
  localparam int TRST_IDX = SHARED_PINS;

  logic testOwnsShared;
  assign testOwnsShared = dedicatedMode | ~ownCtl.inReset;

  for (genvar p = 0; p < SHARED_PINS; p++) begin : gSharedPin
    assign pinSel[p] = testOwnsShared;
  end

  assign pinSel[TRST_IDX] = dedicatedMode | trstResetEn;
  assign trstPadOe        = ~pinSel[TRST_IDX] & userTrstOe;
  assign tdoOe            = pinSel[TDO_IDX] & ownCtl.shiftAny;
  assign pullupEn         = {2{dedicatedMode}};

endmodule

// File: rtl/shared_tap_ctrl.sv
module shared_tap_ctrl
  import tapPkg::*;
#(
  parameter int SHARED_PINS = 3
) (
  input  logic                 tck,
  input  logic                 porN,
  input  logic                 tms,
  input  logic                 trstPin,
  input  logic                 dedicatedMode,
  input  logic                 trstResetEn,
  input  logic                 userTrstOe,
  output logic [STATE_W-1:0]   tapState,
  output logic [SHARED_PINS:0] pinSel,
  output logic                 tdoOe,
  output logic                 trstPadOe,
  output logic [1:0]           pullupEn,
  output logic                 runIdle,
  output logic                 captureDr,
  output logic                 shiftDr,
  output logic                 updateDr,
  output logic                 captureIr,
  output logic                 shiftIr,
  output logic                 updateIr
);

  logic        rstN;
  scanStrobe_t strobes;
  ownCtl_t     ownCtl;

  assign rstN = porN & ~(trstResetEn & ~trstPin);

  tapFsm fsm_i (
    .tck      (tck),
    .rstN     (rstN),
    .tms      (tms),
    .stateOut (tapState),
    .strobes  (strobes),
    .ownCtl   (ownCtl)
  );

  pinOwner #(.SHARED_PINS(SHARED_PINS)) own_i (
    .ownCtl        (ownCtl),
    .dedicatedMode (dedicatedMode),
    .trstResetEn   (trstResetEn),
    .userTrstOe    (userTrstOe),
    .pinSel        (pinSel),
    .tdoOe         (tdoOe),
    .trstPadOe     (trstPadOe),
    .pullupEn      (pullupEn)
  );

  assign runIdle   = strobes.idle;
  assign captureDr = strobes.capDr;
  assign shiftDr   = strobes.shDr;
  assign updateDr  = strobes.updDr;
  assign captureIr = strobes.capIr;
  assign shiftIr   = strobes.shIr;
  assign updateIr  = strobes.updIr;

endmodule

// File: rtl/tapPinChk.sv
module tapPinChk #(
  parameter int SHARED_PINS = 3
) (
  input logic                 tck,
  input logic                 porN,
  input logic                 rstN,
  input logic                 tms,
  input logic                 trstPin,
  input logic                 dedicatedMode,
  input logic                 trstResetEn,
  input logic                 userTrstOe,
  input logic [3:0]           tapState,
  input logic [SHARED_PINS:0] pinSel,
  input logic                 tdoOe,
  input logic                 trstPadOe,
  input logic [1:0]           pullupEn,
  input logic                 runIdle,
  input logic                 captureDr,
  input logic                 shiftDr,
  input logic                 updateDr,
  input logic                 captureIr,
  input logic                 shiftIr,
  input logic                 updateIr
);

  logic [2:0] hiCnt;
  logic       armed;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      hiCnt <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (!tms)          hiCnt <= '0;
      else if (hiCnt < 5) hiCnt <= hiCnt + 3'd1;
    end
  end

  // R3
  five_tms_reset_chk: assert property (@(posedge tck) disable iff (!rstN)
    hiCnt == 3'd5 |-> tapState == 4'hF);

  // R4
  flex_handover_chk: assert property (@(posedge tck) disable iff (!rstN)
    armed && !dedicatedMode && $past(tapState) == 4'hF && !$past(tms)
      |-> pinSel[SHARED_PINS-1:0] == '1);

  // R4
  flex_user_in_reset_chk: assert property (@(posedge tck) disable iff (!porN)
    !dedicatedMode && tapState == 4'hF |-> pinSel[SHARED_PINS-1:0] == '0);

  // R5
  dedicated_own_chk: assert property (@(posedge tck) disable iff (!porN)
    dedicatedMode |-> pinSel == '1);

  // R6
  trst_holds_reset_chk: assert property (@(posedge tck) disable iff (!porN)
    trstResetEn && !trstPin |-> tapState == 4'hF);

  // R7
  trst_user_oe_chk: assert property (@(posedge tck) disable iff (!porN)
    !trstResetEn && !dedicatedMode |-> trstPadOe == userTrstOe);

  // R7
  trst_owned_no_oe_chk: assert property (@(posedge tck) disable iff (!porN)
    pinSel[SHARED_PINS] |-> !trstPadOe);

  // R8
  pullup_mode_chk: assert property (@(posedge tck) disable iff (!porN)
    pullupEn == {2{dedicatedMode}});

  // R9
  strobe_onehot_chk: assert property (@(posedge tck) disable iff (!porN)
    $onehot0({runIdle, captureDr, shiftDr, updateDr, captureIr, shiftIr, updateIr}));

  // R9
  capture_single_chk: assert property (@(posedge tck) disable iff (!rstN)
    captureDr |=> !captureDr);

  // R9
  update_exit_chk: assert property (@(posedge tck) disable iff (!rstN)
    updateIr |=> (tapState == 4'hC || tapState == 4'h7));

  // R10
  tdo_oe_shift_chk: assert property (@(posedge tck) disable iff (!porN)
    tdoOe |-> (tapState == 4'h2 || tapState == 4'hA) && pinSel[SHARED_PINS-1]);

endmodule

bind shared_tap_ctrl tapPinChk #(.SHARED_PINS(SHARED_PINS)) chk_i (.*);

// File: tb/shared_tap_ctrl_tb_top.sv
module shared_tap_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       porN, tms, trstPin, dedicatedMode, trstResetEn, userTrstOe;
  logic [3:0] tapState;
  logic [3:0] pinSel;
  logic       tdoOe, trstPadOe;
  logic [1:0] pullupEn;
  logic       runIdle, captureDr, shiftDr, updateDr, captureIr, shiftIr, updateIr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  shared_tap_ctrl dut_i (
    .tck(clk), .porN(porN), .tms(tms), .trstPin(trstPin),
    .dedicatedMode(dedicatedMode), .trstResetEn(trstResetEn),
    .userTrstOe(userTrstOe), .tapState(tapState), .pinSel(pinSel),
    .tdoOe(tdoOe), .trstPadOe(trstPadOe), .pullupEn(pullupEn),
    .runIdle(runIdle), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .captureIr(captureIr), .shiftIr(shiftIr),
    .updateIr(updateIr)
  );

  // {tms, expected state after the edge}, starting from F
  localparam logic [4:0] VEC [25] = '{
    {1'b0, 4'hC}, {1'b0, 4'hC}, {1'b1, 4'h7}, {1'b0, 4'h6}, {1'b0, 4'h2},
    {1'b0, 4'h2}, {1'b1, 4'h1}, {1'b0, 4'h3}, {1'b1, 4'h0}, {1'b0, 4'h2},
    {1'b1, 4'h1}, {1'b1, 4'h5}, {1'b1, 4'h7}, {1'b1, 4'h4}, {1'b0, 4'hE},
    {1'b0, 4'hA}, {1'b1, 4'h9}, {1'b0, 4'hB}, {1'b1, 4'h8}, {1'b1, 4'hD},
    {1'b0, 4'hC}, {1'b1, 4'h7}, {1'b1, 4'h4}, {1'b1, 4'hF}, {1'b1, 4'hF}
  };

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic tmsVal);
    @(negedge clk);
    tms = tmsVal;
    @(posedge clk);
    #2;
  endtask

  task automatic checkStrobes(input logic [3:0] st);
    logic [6:0] exp, act;
    exp = {st == 4'hC, st == 4'h6, st == 4'h2, st == 4'h5,
           st == 4'hE, st == 4'hA, st == 4'hD};
    act = {runIdle, captureDr, shiftDr, updateDr, captureIr, shiftIr, updateIr};
    check(act == exp, "R9 strobes", {1'b0, act}, {1'b0, exp});
  endtask

  task automatic resetWith(input logic ded, input logic trEn);
    @(negedge clk);
    porN = 1'b0;
    dedicatedMode = ded;
    trstResetEn = trEn;
    tms = 1'b1;
    #12;
    @(negedge clk);
    porN = 1'b1;
  endtask

  initial begin
    porN = 1'b0; tms = 1'b1; trstPin = 1'b1;
    dedicatedMode = 1'b0; trstResetEn = 1'b0; userTrstOe = 1'b0;
    #23;
    check(tapState == 4'hF, "R1 reset state", {4'h0, tapState}, 8'h0F);
    check(pinSel[2:0] == 3'b000, "R4 user pins in reset", {5'h0, pinSel[2:0]}, 8'h00);
    check(pullupEn == 2'b00, "R8 flexible pullups", {6'h0, pullupEn}, 8'h00);
    @(negedge clk);
    porN = 1'b1;
    #1;
    check(tapState == 4'hF, "R1 after release", {4'h0, tapState}, 8'h0F);

    // R2 R4 R9 R10: walk of the state graph in flexible mode
    for (int i = 0; i < 25; i++) begin
      logic [3:0] expSt;
      expSt = VEC[i][3:0];
      step(VEC[i][4]);
      check(tapState == expSt, "R2 transition", {4'h0, tapState}, {4'h0, expSt});
      check(pinSel[2:0] == ((expSt == 4'hF) ? 3'b000 : 3'b111), "R4 ownership",
            {5'h0, pinSel[2:0]}, (expSt == 4'hF) ? 8'h00 : 8'h07);
      checkStrobes(expSt);
      check(tdoOe == (expSt == 4'h2 || expSt == 4'hA), "R10 tdo enable",
            {7'h0, tdoOe}, {7'h0, (expSt == 4'h2 || expSt == 4'hA)});
    end

    // R4 handover on first tms-low edge
    step(1'b0);
    check(pinSel[2:0] == 3'b111, "R4 handover", {5'h0, pinSel[2:0]}, 8'h07);
    // to shift-IR
    step(1'b1); step(1'b1); step(1'b0); step(1'b0);
    check(tapState == 4'hA, "R2 reach shift-IR", {4'h0, tapState}, 8'h0A);
    // R3: four highs not enough, fifth returns
    step(1'b1); step(1'b1); step(1'b1); step(1'b1);
    check(tapState != 4'hF, "R3 four highs", {4'h0, tapState}, 8'h04);
    step(1'b1);
    check(tapState == 4'hF, "R3 five highs", {4'h0, tapState}, 8'h0F);
    check(pinSel[2:0] == 3'b000, "R4 returned to user", {5'h0, pinSel[2:0]}, 8'h00);

    // R7: test reset disabled, pin ignored
    step(1'b0); step(1'b1); step(1'b0); step(1'b0);
    @(negedge clk);
    trstPin = 1'b0;
    userTrstOe = 1'b1;
    #1;
    check(tapState == 4'h2, "R7 trst ignored async", {4'h0, tapState}, 8'h02);
    step(1'b0);
    check(tapState == 4'h2, "R7 trst ignored clocked", {4'h0, tapState}, 8'h02);
    check(pinSel[3] == 1'b0, "R7 trst user owned", {7'h0, pinSel[3]}, 8'h00);
    check(trstPadOe == 1'b1, "R7 trst oe follows user", {7'h0, trstPadOe}, 8'h01);
    @(negedge clk);
    userTrstOe = 1'b0;
    #1;
    check(trstPadOe == 1'b0, "R7 trst oe off", {7'h0, trstPadOe}, 8'h00);
    trstPin = 1'b1;

    // R6: test reset enabled
    resetWith(1'b0, 1'b1);
    userTrstOe = 1'b1;
    #1;
    check(trstPadOe == 1'b0, "R7 owned trst no oe", {7'h0, trstPadOe}, 8'h00);
    check(pinSel[3] == 1'b1, "R7 trst test owned", {7'h0, pinSel[3]}, 8'h01);
    step(1'b0); step(1'b1); step(1'b0); step(1'b0);
    check(tapState == 4'h2, "R2 reach shift-DR", {4'h0, tapState}, 8'h02);
    #1;
    trstPin = 1'b0;
    #1;
    check(tapState == 4'hF, "R6 async trst", {4'h0, tapState}, 8'h0F);
    step(1'b0); step(1'b0);
    check(tapState == 4'hF, "R6 parked", {4'h0, tapState}, 8'h0F);
    @(negedge clk);
    trstPin = 1'b1;
    step(1'b0);
    check(tapState == 4'hC, "R6 release", {4'h0, tapState}, 8'h0C);

    // R5 R8: dedicated mode
    resetWith(1'b1, 1'b0);
    #1;
    check(tapState == 4'hF, "R1 dedicated reset", {4'h0, tapState}, 8'h0F);
    check(pinSel == 4'b1111, "R5 dedicated in reset", {4'h0, pinSel}, 8'h0F);
    check(pullupEn == 2'b11, "R8 dedicated pullups", {6'h0, pullupEn}, 8'h03);
    check(trstPadOe == 1'b0, "R7 dedicated trst oe", {7'h0, trstPadOe}, 8'h00);
    step(1'b0); step(1'b1); step(1'b0); step(1'b0);
    check(pinSel == 4'b1111, "R5 dedicated in shift", {4'h0, pinSel}, 8'h0F);
    check(tdoOe == 1'b1, "R10 dedicated tdo", {7'h0, tdoOe}, 8'h01);
    step(1'b1); step(1'b1); step(1'b1); step(1'b1); step(1'b1);
    check(tapState == 4'hF && pinSel == 4'b1111, "R5 dedicated back in reset",
          {tapState, pinSel}, 8'hFF);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule